// File: doc/BRIEF.md
# Power-State Reset Pin Controller

This block owns the active-low, open-drain system reset line of a power-management controller. It follows the controller's power state and decides when the line is pulled low. In OFF it always pulls low. In SLEEP a configuration bit decides. In ON it keeps the line low until the power-up or wake sequence reports completion. It then keeps it low for a further programmable stretch, counted in millisecond ticks, and only then releases it.

The block also watches the line. When something outside pulls it low while the block itself is not pulling, the block emits a one-cycle hardware-reset request. That request asks the rest of the chip to reset its control registers, except the real-time-clock domain, and to start a fresh start-up sequence. The pad sample is synchronised and glitch-filtered first. A mask bit can silence these requests while in SLEEP.

A small control register holds the mask, the SLEEP drive policy and the delay selection. Writes to it take effect only while a security-unlock input is high.

Top module: `rst_pin_ctrl`

## Requirements
- R1: After reset the block pulls the line low, `cfg_rdata` reads 0x33, and no request pulse appears.
- R2: With `pwr_state` = 00 (OFF) the line is pulled low on every cycle, whatever the configuration.
- R3: With `pwr_state` = 01 (SLEEP) the line is pulled low exactly when register bit 4 (sleep drive) is 1, and released when it is 0.
- R4: On entry to `pwr_state` = 10 (ON) the line stays low indefinitely until `seq_done` is pulsed. After the pulse it is released in the cycle after the N-th `tick_ms` pulse that follows the `seq_done` cycle.
- R5: N is chosen by register bits 1:0: 00 gives 3, 01 gives 11, 10 gives 51 and 11 gives 101 ticks.
- R6: A write on `cfg_wr_en` updates the register only when `cfg_unlock` is 1. The stored fields are bit 5 (sleep mask), bit 4 (sleep drive) and bits 1:0 (delay select), and all other bits read 0. A write with `cfg_unlock` = 0 leaves the readback unchanged.
- R7: An external low on the pad lasting at least FILT_LEN + 1 clocks yields exactly one `hw_reset_req` pulse, one cycle wide. A low lasting 2 clocks yields none.
- R8: In SLEEP with register bit 5 = 1, an external low produces no request. With bit 5 = 0 it produces one.
- R9: Leaving ON during the release countdown cancels it, so that on return to ON the line is held until a new `seq_done`. A `seq_done` during a countdown restarts the full count.
- R10: The block's own pulling of the line, and its release, never produce a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_state | input | 2 | Power state: 00 OFF, 01 SLEEP, 10 ON (11 treated like OFF) |
| seq_done | input | 1 | One-cycle pulse: ON or wake transition finished |
| tick_ms | input | 1 | One-cycle enable at 1 kHz |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_unlock | input | 1 | Security unlock; writes accepted only while high |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback |
| pad_in | input | 1 | Sampled level of the reset pad |
| pad_drive_low | output | 1 | 1 enables the open-drain pull-down of the pad |
| hw_reset_req | output | 1 | One-cycle external hardware-reset request |

## Verification
The hardest situation to reach from the ports is a state change or a second `seq_done` landing in the middle of a long countdown. The bench reaches it by issuing `seq_done`, letting a few ticks pass, then leaving ON or repeating `seq_done`, and counting ticks afresh until the release. The pad is modelled as a wired-AND of the block's own pull-down and a bench-controlled external pull. This lets the bench show that self-driven edges stay silent while genuine external lows, including short glitches, are told apart.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [1:0] {
    PS_OFF   = 2'b00,
    PS_SLEEP = 2'b01,
    PS_ON    = 2'b10,
    PS_BAD   = 2'b11
  } pwr_state_e;

  typedef struct packed {
    logic       slp_mask;
    logic       slp_drive;
    logic [1:0] dly_sel;
  } rst_cfg_t;

  typedef enum logic [1:0] {
    TM_HOLD  = 2'b00,
    TM_COUNT = 2'b01,
    TM_FREE  = 2'b10
  } tmr_state_e;

  localparam rst_cfg_t CFG_RESET = '{slp_mask: 1'b1, slp_drive: 1'b1, dly_sel: 2'b11};

  function automatic int unsigned pick_delay(input logic [1:0] sel,
                                             input int unsigned d0, input int unsigned d1,
                                             input int unsigned d2, input int unsigned d3);
    case (sel)
      2'b00:   return d0;
      2'b01:   return d1;
      2'b10:   return d2;
      default: return d3;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic [7:0] cfg_to_byte(input rst_cfg_t c);
    return {2'b00, c.slp_mask, c.slp_drive, 2'b00, c.dly_sel};
  endfunction

  function automatic rst_cfg_t byte_to_cfg(input logic [7:0] b);
    rst_cfg_t c;
    c.slp_mask  = b[5];
    c.slp_drive = b[4];
    c.dly_sel   = b[1:0];
    return c;
  endfunction

endpackage

// File: rtl/rpc_cfg_reg.sv
module rpc_cfg_reg
  import rpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       unlock,
  input  logic [7:0] wdata,
  output rst_cfg_t   cfg,
  output logic [7:0] rdata
);

  logic wr_accept;
  assign wr_accept = wr_en & unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg <= CFG_RESET;
    else if (wr_accept) cfg <= byte_to_cfg(wdata);
  end

  assign rdata = cfg_to_byte(cfg);

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && unlock) |=> $stable(rdata)); // R6
  AST_CFG_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlock) |=> (rdata == ($past(wdata) & 8'h33))); // R6

endmodule

// File: rtl/rpc_release_timer.sv
module rpc_release_timer
  import rpc_pkg::*;
#(
  parameter int unsigned DLY_T0 = 3,
  parameter int unsigned DLY_T1 = 11,
  parameter int unsigned DLY_T2 = 51,
  parameter int unsigned DLY_T3 = 101,
  localparam int unsigned DLY_MAX = max4(DLY_T0, DLY_T1, DLY_T2, DLY_T3),
  localparam int unsigned CNT_W   = $clog2(DLY_MAX + 1)
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_on,
  input  logic       seq_done,
  input  logic       tick,
  input  logic [1:0] dly_sel,
  output logic       released,
  output logic       counting
);

  tmr_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic             load_evt;
  logic             last_tick_evt;

  assign load_val      = CNT_W'(pick_delay(dly_sel, DLY_T0, DLY_T1, DLY_T2, DLY_T3));
  assign load_evt      = in_on & seq_done;
  assign last_tick_evt = in_on & (st == TM_COUNT) & tick & (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= TM_HOLD;
      cnt <= '0;
    end else if (!in_on) begin
      st  <= TM_HOLD;
      cnt <= '0;
    end else if (load_evt) begin
      st  <= TM_COUNT;
      cnt <= load_val;
    end else if (last_tick_evt) begin
      st  <= TM_FREE;
      cnt <= '0;
    end else if (st == TM_COUNT && tick) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign released = (st == TM_FREE);
  assign counting = (st == TM_COUNT);

  AST_CANCEL_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_on |=> (!released && !counting)); // R9
  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (counting && cnt == CNT_W'(pick_delay($past(dly_sel), DLY_T0, DLY_T1, DLY_T2, DLY_T3)))); // R5
  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && in_on && !seq_done && !tick) |=> (counting && $stable(cnt))); // R4

endmodule

// File: rtl/rpc_ext_detect.sv
module rpc_ext_detect #(
  parameter int unsigned FILT_LEN = 3,
  localparam int unsigned BLANK   = FILT_LEN + 3,
  localparam int unsigned FCNT_W  = $clog2(FILT_LEN + 1),
  localparam int unsigned BCNT_W  = $clog2(BLANK + 1)
)(
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic self_drive,
  input  logic allow,
  output logic req_pulse
);

  logic [1:0]        sync_q;
  logic              pad_s;
  logic [BCNT_W-1:0] blank_cnt;
  logic              blanked;
  logic              ext_raw;
  logic              ext_filt;
  logic              ext_filt_d;
  logic [FCNT_W-1:0] fcnt;
  logic              filt_rise_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pad_in};
  end
  assign pad_s = sync_q[1];

  // own pull-down, plus the synchroniser/filter latency after it lets go
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 blank_cnt <= BCNT_W'(BLANK);
    else if (self_drive)        blank_cnt <= BCNT_W'(BLANK);
    else if (blank_cnt != '0)   blank_cnt <= blank_cnt - BCNT_W'(1);
  end
  assign blanked = self_drive | (blank_cnt != '0);
  assign ext_raw = ~pad_s & ~blanked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_filt <= 1'b0;
      fcnt     <= '0;
    end else if (ext_raw == ext_filt) begin
      fcnt <= '0;
    end else if (fcnt == FCNT_W'(FILT_LEN - 1)) begin
      ext_filt <= ext_raw;
      fcnt     <= '0;
    end else begin
      fcnt <= fcnt + FCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_filt_d <= 1'b0;
    else        ext_filt_d <= ext_filt;
  end

  assign filt_rise_evt = ext_filt & ~ext_filt_d;
  assign req_pulse     = filt_rise_evt & allow;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> !req_pulse); // R7
  AST_FILT_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_filt) |-> $past(ext_raw)); // R7

endmodule

// File: rtl/rst_pin_ctrl.sv
module rst_pin_ctrl
  import rpc_pkg::*;
#(
  parameter int unsigned DLY_T0   = 3,
  parameter int unsigned DLY_T1   = 11,
  parameter int unsigned DLY_T2   = 51,
  parameter int unsigned DLY_T3   = 101,
  parameter int unsigned FILT_LEN = 3
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_state,
  input  logic       seq_done,
  input  logic       tick_ms,
  input  logic       cfg_wr_en,
  input  logic       cfg_unlock,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       pad_in,
  output logic       pad_drive_low,
  output logic       hw_reset_req
);

  pwr_state_e ps;
  rst_cfg_t   cfg;
  logic       in_on;
  logic       in_sleep;
  logic       tmr_released;
  logic       tmr_counting;
  logic       self_drive;
  logic       allow_req;

  assign ps       = pwr_state_e'(pwr_state);
  assign in_on    = (ps == PS_ON);
  assign in_sleep = (ps == PS_SLEEP);

  rpc_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .unlock (cfg_unlock),
    .wdata  (cfg_wdata),
    .cfg    (cfg),
    .rdata  (cfg_rdata)
  );

  rpc_release_timer #(
    .DLY_T0 (DLY_T0), .DLY_T1 (DLY_T1), .DLY_T2 (DLY_T2), .DLY_T3 (DLY_T3)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_on    (in_on),
    .seq_done (seq_done),
    .tick     (tick_ms),
    .dly_sel  (cfg.dly_sel),
    .released (tmr_released),
    .counting (tmr_counting)
  );

  always_comb begin
    case (ps)
      PS_SLEEP: self_drive = cfg.slp_drive;
      PS_ON:    self_drive = ~tmr_released;
      default:  self_drive = 1'b1;
    endcase
  end
  assign pad_drive_low = self_drive;

  assign allow_req = ~(in_sleep & cfg.slp_mask);

  rpc_ext_detect #(.FILT_LEN (FILT_LEN)) u_ext (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_in     (pad_in),
    .self_drive (self_drive),
    .allow      (allow_req),
    .req_pulse  (hw_reset_req)
  );

  AST_OFF_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00) |-> pad_drive_low); // R2
  AST_ON_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pad_drive_low) && in_on && $past(in_on)) |-> ($past(tick_ms) && $past(tmr_counting))); // R4

endmodule

// File: tb/rst_pin_ctrl_test.sv
module rst_pin_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwr_state = 2'b00;
  logic       seq_done = 1'b0;
  logic       tick_ms = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic       cfg_unlock = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       pad_in;
  logic       pad_drive_low;
  logic       hw_reset_req;
  logic       ext_pull = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int req_seen = 0;
  int req_run = 0;
  int req_wide = 0;
  bit done = 1'b0;
  int tdiv = 0;

  localparam logic [1:0] S_OFF = 2'b00, S_SLP = 2'b01, S_ON = 2'b10;

  always #10 clk = ~clk;

  assign pad_in = ~(pad_drive_low | ext_pull);

  rst_pin_ctrl uut (
    .clk (clk), .rst_n (rst_n), .pwr_state (pwr_state), .seq_done (seq_done),
    .tick_ms (tick_ms), .cfg_wr_en (cfg_wr_en), .cfg_unlock (cfg_unlock),
    .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .pad_in (pad_in),
    .pad_drive_low (pad_drive_low), .hw_reset_req (hw_reset_req)
  );

  always @(negedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick_ms <= (tdiv == 3);
  end

  always @(posedge clk) begin
    if (rst_n && hw_reset_req) begin
      req_seen <= req_seen + 1;
      req_run  <= req_run + 1;
      if (req_run >= 1) req_wide <= req_wide + 1;
    end else begin
      req_run <= 0;
    end
  end

  function automatic int ticks_for(input logic [1:0] sel);
    if (sel == 2'b00) return 3;
    if (sel == 2'b01) return 11;
    if (sel == 2'b10) return 51;
    return 101;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] d, input logic unl);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wdata = d; cfg_unlock = unl;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_unlock = 1'b0;
  endtask

  task automatic set_state(input logic [1:0] s);
    @(negedge clk);
    pwr_state = s;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    seq_done = 1'b1;
    @(posedge clk);
    #1 seq_done = 1'b0;
  endtask

  // counts ticks after the seq_done edge until the pull-down releases
  task automatic count_to_release(output int ticks);
    ticks = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      if (tick_ms) ticks++;
      #1;
      if (!pad_drive_low) break;
    end
  endtask

  task automatic t_reset();
    int r0;
    r0 = req_seen;
    idle(3);
    check("R1 drive after reset", pad_drive_low, 1);
    check("R1 cfg readback", cfg_rdata, 8'h33);
    idle(12);
    check("R1 no request", req_seen - r0, 0);
  endtask

  task automatic t_lock();
    wr_cfg(8'h00, 1'b0);
    idle(1);
    check("R6 locked write ignored", cfg_rdata, 8'h33);
    wr_cfg(8'hCC, 1'b1);
    idle(1);
    check("R6 unused bits read zero", cfg_rdata, 8'h00);
    wr_cfg(8'hFF, 1'b1);
    idle(1);
    check("R6 unlocked write", cfg_rdata, 8'h33);
  endtask

  task automatic t_off();
    int r0;
    wr_cfg(8'h00, 1'b1);
    set_state(S_OFF);
    r0 = req_seen;
    idle(2);
    check("R2 OFF drives low", pad_drive_low, 1);
    ext_pull = 1'b1; idle(10); ext_pull = 1'b0; idle(10);
    check("R2 OFF still low", pad_drive_low, 1);
    check("R10 no request while self driving", req_seen - r0, 0);
  endtask

  task automatic t_sleep();
    wr_cfg(8'h10, 1'b1);
    set_state(S_SLP); idle(2);
    check("R3 SLEEP drive bit 1", pad_drive_low, 1);
    wr_cfg(8'h00, 1'b1); idle(1);
    check("R3 SLEEP drive bit 0", pad_drive_low, 0);
    set_state(S_OFF); idle(2);
  endtask

  task automatic t_release(input logic [1:0] sel);
    int tk;
    int r0;
    wr_cfg({6'b000000, sel}, 1'b1);
    set_state(S_OFF); idle(3);
    r0 = req_seen;
    set_state(S_ON); idle(40);
    check("R4 held until seq_done", pad_drive_low, 1);
    pulse_done();
    count_to_release(tk);
    check($sformatf("R5 ticks for select %0d", sel), tk, ticks_for(sel));
    check("R4 released", pad_drive_low, 0);
    idle(20);
    check("R10 own release gives no request", req_seen - r0, 0);
  endtask

  task automatic t_cancel();
    int tk;
    wr_cfg(8'h01, 1'b1);
    set_state(S_OFF); idle(3);
    set_state(S_ON);
    pulse_done();
    idle(20);
    set_state(S_SLP); idle(3);
    set_state(S_ON); idle(80);
    check("R9 re-entry held after cancel", pad_drive_low, 1);
    pulse_done();
    idle(22);
    pulse_done();
    count_to_release(tk);
    check("R9 restart gives full count", tk, 11);
  endtask

  task automatic t_ext();
    int r0;
    wr_cfg(8'h00, 1'b1);
    set_state(S_OFF); idle(3);
    set_state(S_ON); pulse_done();
    idle(40);
    r0 = req_seen;
    ext_pull = 1'b1; idle(2); ext_pull = 1'b0; idle(15);
    check("R7 glitch ignored", req_seen - r0, 0);
    r0 = req_seen;
    ext_pull = 1'b1; idle(12); ext_pull = 1'b0; idle(15);
    check("R7 one request", req_seen - r0, 1);
    check("R7 pulse single cycle", req_wide, 0);
  endtask

  task automatic t_mask();
    int r0;
    wr_cfg(8'h20, 1'b1);
    set_state(S_SLP); idle(15);
    r0 = req_seen;
    ext_pull = 1'b1; idle(12); ext_pull = 1'b0; idle(15);
    check("R8 masked in SLEEP", req_seen - r0, 0);
    wr_cfg(8'h00, 1'b1); idle(3);
    r0 = req_seen;
    ext_pull = 1'b1; idle(12); ext_pull = 1'b0; idle(15);
    check("R8 unmasked in SLEEP", req_seen - r0, 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_lock();
    t_off();
    t_sleep();
    for (int s = 0; s < 4; s++) t_release(2'(s));
    t_cancel();
    t_ext();
    t_mask();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule